// File: doc/BRIEF.md
# Adaptive Virtual Channel Selection Allocator

This block picks the virtual channel that a packet header will occupy on one output port of a network-on-chip router. The virtual channels are split into lanes, and a packet's destination decides its lane. A freshly injected packet always asks for the lowest channel of its lane. When that channel is taken, the packet climbs one channel per attempt toward the top of its lane and never drops back. Under light load only the lowest channel of each lane carries traffic, so the upper channels can stay power-gated until contention actually occurs. Only the bottom channel layer has to be deadlock-free, because movement between layers is upward only.

The grouping comes from a two-bit configuration input: one lane spanning every channel, two lanes split by destination parity, or one channel per lane picked by destination modulo the channel count. Each cycle the requester presents the destination, its current channel, whether it is new, and the per-channel busy flags. The allocator answers in the same cycle with either a grant on a channel or a blocked flag and the channel to request on the next attempt.

Top module: `vc_select_alloc`

## Requirements
- R1: With `req_valid` low, `gnt` and `blocked` are 0 and `out_vc` is 0.
- R2: A request with `req_new` high asks for the lowest channel of its lane whatever `req_vc` holds.
- R3: With `lane_mode` = 0, all NUM_VC channels form one lane, from channel 0 up to channel NUM_VC-1.
- R4: With `lane_mode` = 1, an even destination uses the lower half of the channels and an odd destination the upper half (channels 0–1 and 2–3 when NUM_VC = 4).
- R5: With `lane_mode` = 2 or 3, a packet uses only channel (destination mod NUM_VC).
- R6: When the requested channel has its `vc_busy` bit (bit i = channel i) clear, `gnt` is 1, `blocked` is 0 and `out_vc` equals that channel, in the same cycle.
- R7: When the requested channel is busy and lies below the top of its lane, `blocked` is 1 and `out_vc` is the requested channel plus one.
- R8: When the requested channel is busy and is the top of its lane, `blocked` is 1 and `out_vc` stays on the requested channel, with no wrap to the lane base.
- R9: A continuing request (`req_new` low) whose `req_vc` lies outside its lane is treated as a request for the lane's lowest channel.
- R10: `gnt` and `blocked` are never both 1, and exactly one of them is 1 while `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the temporal checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| req_valid | input | 1 | A header requests a channel this cycle |
| req_new | input | 1 | Header is newly injected |
| req_dst | input | DST_W | Destination identifier |
| req_vc | input | VC_W | Channel the header currently asks for |
| vc_busy | input | NUM_VC | Per-channel busy flags, bit i = channel i |
| lane_mode | input | 2 | 0 one lane, 1 two lanes, 2/3 one channel per lane |
| gnt | output | 1 | Request granted on `out_vc` |
| blocked | output | 1 | Request refused this cycle |
| out_vc | output | VC_W | Granted channel, or channel to ask for next |

## Verification
Every result is combinational, so grant, blocked flag and channel are due in the same cycle as the request with no register on the path. The bench changes inputs at the falling clock edge and samples the outputs one nanosecond later, well before the next rising edge, so each sample sees only the current request. A directed vector table covers each grouping mode and the lane edges, and an exhaustive sweep over mode, destination, current channel, busy flags and the new-packet bit compares against a model written from the requirements.

// File: rtl/vcsel_pkg.sv
package vcsel_pkg;

  typedef enum logic [1:0] {
    MODE_ONE_LANE = 2'd0,
    MODE_TWO_LANE = 2'd1,
    MODE_PER_VC   = 2'd2,
    MODE_PER_VC_B = 2'd3
  } lane_mode_e;

  // Number of lanes the channels are split into for a given mode.
  function automatic int unsigned lane_count(input logic [1:0] mode,
                                             input int unsigned num_vc);
    case (lane_mode_e'(mode))
      MODE_ONE_LANE: lane_count = 1;
      MODE_TWO_LANE: lane_count = (num_vc >= 2) ? 2 : 1;
      default:       lane_count = num_vc;
    endcase
  endfunction

  // Channels per lane.
  function automatic int unsigned lane_width(input logic [1:0] mode,
                                             input int unsigned num_vc);
    lane_width = num_vc / lane_count(mode, num_vc);
  endfunction

  // Lowest channel of the lane a destination falls in.
  function automatic int unsigned lane_base(input int unsigned dst,
                                            input logic [1:0] mode,
                                            input int unsigned num_vc);
    lane_base = (dst % lane_count(mode, num_vc)) * lane_width(mode, num_vc);
  endfunction

endpackage

// File: rtl/vcsel_lane_decode.sv
module vcsel_lane_decode
  import vcsel_pkg::*;
#(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned DST_W  = 6,
  parameter int unsigned VC_W   = 2
) (
  input  logic [DST_W-1:0]  dst,
  input  logic [1:0]        mode,
  output logic [VC_W-1:0]   base,
  output logic [VC_W-1:0]   top,
  output logic [NUM_VC-1:0] lane_mask
);

  int unsigned base_i;
  int unsigned top_i;

  always_comb begin
    base_i = lane_base(int'(dst), mode, NUM_VC);
    top_i  = base_i + lane_width(mode, NUM_VC) - 1;
  end

  assign base = VC_W'(base_i);
  assign top  = VC_W'(top_i);

  for (genvar i = 0; i < NUM_VC; i++) begin : g_mask
    assign lane_mask[i] = (VC_W'(i) >= base) && (VC_W'(i) <= top);
  end

endmodule

// File: rtl/vcsel_want.sv
module vcsel_want #(
  parameter int unsigned VC_W = 2
) (
  input  logic            req_new,
  input  logic [VC_W-1:0] cur_vc,
  input  logic [VC_W-1:0] base,
  input  logic [VC_W-1:0] top,
  output logic [VC_W-1:0] want_vc,
  output logic            remapped
);

  logic outside;

  assign outside  = (cur_vc < base) || (cur_vc > top);
  assign remapped = !req_new && outside;
  assign want_vc  = (req_new || outside) ? base : cur_vc;

endmodule

// File: rtl/vcsel_step.sv
module vcsel_step #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned VC_W   = 2
) (
  input  logic              valid,
  input  logic [VC_W-1:0]   want_vc,
  input  logic [VC_W-1:0]   top,
  input  logic [NUM_VC-1:0] busy,
  output logic              hit_busy,
  output logic              at_top,
  output logic              gnt,
  output logic              blocked,
  output logic [VC_W-1:0]   out_vc
);

  logic [VC_W-1:0] climb_vc;

  assign hit_busy = busy[want_vc];
  assign at_top   = (want_vc == top);
  assign climb_vc = at_top ? want_vc : want_vc + VC_W'(1);
  assign gnt      = valid && !hit_busy;
  assign blocked  = valid && hit_busy;

  always_comb begin
    if (!valid)        out_vc = '0;
    else if (hit_busy) out_vc = climb_vc;
    else               out_vc = want_vc;
  end

endmodule

// File: rtl/vc_select_alloc.sv
module vc_select_alloc #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned DST_W  = 6,
  localparam int unsigned VC_W  = (NUM_VC > 2) ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_new,
  input  logic [DST_W-1:0]  req_dst,
  input  logic [VC_W-1:0]   req_vc,
  input  logic [NUM_VC-1:0] vc_busy,
  input  logic [1:0]        lane_mode,
  output logic              gnt,
  output logic              blocked,
  output logic [VC_W-1:0]   out_vc
);

  logic [VC_W-1:0]   lane_lo;
  logic [VC_W-1:0]   lane_hi;
  logic [NUM_VC-1:0] lane_mask;
  logic [VC_W-1:0]   want_vc;
  logic              remapped;
  logic              hit_busy;
  logic              at_top;

  vcsel_lane_decode #(.NUM_VC(NUM_VC), .DST_W(DST_W), .VC_W(VC_W)) u_lane (
    .dst       (req_dst),
    .mode      (lane_mode),
    .base      (lane_lo),
    .top       (lane_hi),
    .lane_mask (lane_mask)
  );

  vcsel_want #(.VC_W(VC_W)) u_want (
    .req_new  (req_new),
    .cur_vc   (req_vc),
    .base     (lane_lo),
    .top      (lane_hi),
    .want_vc  (want_vc),
    .remapped (remapped)
  );

  vcsel_step #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_step (
    .valid    (req_valid),
    .want_vc  (want_vc),
    .top      (lane_hi),
    .busy     (vc_busy),
    .hit_busy (hit_busy),
    .at_top   (at_top),
    .gnt      (gnt),
    .blocked  (blocked),
    .out_vc   (out_vc)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!gnt && !blocked && out_vc == '0));

  assert_new_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_new && gnt) |-> (out_vc == lane_lo));

  assert_in_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> lane_mask[out_vc]);

  assert_grant_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> !vc_busy[out_vc]);

  assert_climb_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !at_top) |-> (out_vc == want_vc + VC_W'(1)));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_new && lane_mask[req_vc]) |-> (out_vc >= req_vc));

  assert_remap_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && remapped && gnt) |-> (out_vc == lane_lo));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt, blocked}) && (req_valid == (gnt || blocked)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid) && req_valid &&
     $stable({req_new, req_dst, req_vc, vc_busy, lane_mode}))
    |-> ($stable(out_vc) && $stable(gnt)));

endmodule

// File: tb/tb_vc_select_alloc.sv
module tb_vc_select_alloc;

  localparam int unsigned NUM_VC = 4;
  localparam int unsigned DST_W  = 6;
  localparam int unsigned VC_W   = 2;
  localparam int NVEC = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_new = 1'b0;
  logic [DST_W-1:0] req_dst = '0;
  logic [VC_W-1:0] req_vc = '0;
  logic [NUM_VC-1:0] vc_busy = '0;
  logic [1:0] lane_mode = '0;
  logic gnt, blocked;
  logic [VC_W-1:0] out_vc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vc_select_alloc #(.NUM_VC(NUM_VC), .DST_W(DST_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_new(req_new),
    .req_dst(req_dst), .req_vc(req_vc), .vc_busy(vc_busy),
    .lane_mode(lane_mode), .gnt(gnt), .blocked(blocked), .out_vc(out_vc)
  );

  // Vector: {tag[3:0], new, dst[5:0], cur[1:0], busy[3:0], mode[1:0], eg, eb, evc[1:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {4'd3, 1'b1, 6'd5, 2'd0, 4'b0000, 2'd0, 1'b1, 1'b0, 2'd0},
    {4'd3, 1'b0, 6'd5, 2'd1, 4'b0010, 2'd0, 1'b0, 1'b1, 2'd2},
    {4'd7, 1'b0, 6'd5, 2'd2, 4'b0110, 2'd0, 1'b0, 1'b1, 2'd3},
    {4'd8, 1'b0, 6'd5, 2'd3, 4'b1000, 2'd0, 1'b0, 1'b1, 2'd3},
    {4'd4, 1'b1, 6'd6, 2'd0, 4'b0000, 2'd1, 1'b1, 1'b0, 2'd0},
    {4'd4, 1'b1, 6'd7, 2'd0, 4'b0000, 2'd1, 1'b1, 1'b0, 2'd2},
    {4'd7, 1'b0, 6'd7, 2'd2, 4'b0100, 2'd1, 1'b0, 1'b1, 2'd3},
    {4'd8, 1'b0, 6'd7, 2'd3, 4'b1000, 2'd1, 1'b0, 1'b1, 2'd3},
    {4'd8, 1'b0, 6'd6, 2'd1, 4'b0010, 2'd1, 1'b0, 1'b1, 2'd1},
    {4'd5, 1'b1, 6'd6, 2'd0, 4'b0000, 2'd2, 1'b1, 1'b0, 2'd2},
    {4'd5, 1'b0, 6'd6, 2'd2, 4'b0100, 2'd2, 1'b0, 1'b1, 2'd2},
    {4'd5, 1'b1, 6'd9, 2'd0, 4'b0000, 2'd3, 1'b1, 1'b0, 2'd1},
    {4'd9, 1'b0, 6'd7, 2'd0, 4'b0000, 2'd1, 1'b1, 1'b0, 2'd2},
    {4'd6, 1'b0, 6'd4, 2'd3, 4'b0111, 2'd0, 1'b1, 1'b0, 2'd3},
    {4'd2, 1'b1, 6'd3, 2'd2, 4'b0000, 2'd0, 1'b1, 1'b0, 2'd0}
  };

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic eg, input logic eb,
                       input logic [VC_W-1:0] ev);
    checks++;
    if (gnt !== eg || blocked !== eb || out_vc !== ev) begin
      fails++;
      $display("FAIL %s: gnt=%0b blocked=%0b vc=%0d, expected gnt=%0b blocked=%0b vc=%0d",
               tag, gnt, blocked, out_vc, eg, eb, ev);
    end
  endtask

  task automatic apply(input logic nw, input int dst, input int cur,
                       input logic [3:0] busy, input int mode);
    @(negedge clk);
    req_valid = 1'b1;
    req_new   = nw;
    req_dst   = DST_W'(dst);
    req_vc    = VC_W'(cur);
    vc_busy   = busy;
    lane_mode = 2'(mode);
    #1;
  endtask

  initial begin
    // R1 during reset and while idle
    repeat (2) @(negedge clk);
    #1 check("R1", 1'b0, 1'b0, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    req_dst = 6'd7; req_vc = 2'd3; vc_busy = 4'b1111; lane_mode = 2'd1;
    #1 check("R1", 1'b0, 1'b0, 2'd0);

    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][18], int'(VEC[k][17:12]), int'(VEC[k][11:10]),
            VEC[k][9:6], int'(VEC[k][5:4]));
      check(tag_name(int'(VEC[k][22:19])), VEC[k][3], VEC[k][2], VEC[k][1:0]);
    end

    // Exhaustive sweep against an independent model (R2..R10)
    for (int mode = 0; mode < 4; mode++) begin
      for (int dst = 0; dst < 8; dst++) begin
        for (int cur = 0; cur < 4; cur++) begin
          for (int b = 0; b < 16; b++) begin
            for (int nw = 0; nw < 2; nw++) begin
              int lanes, wid, lo, hi, want;
              logic [3:0] busy;
              string tag;
              busy  = 4'(b);
              lanes = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
              wid   = 4 / lanes;
              lo    = (dst % lanes) * wid;
              hi    = lo + wid - 1;
              if (nw == 1) begin
                want = lo; tag = "R2";
              end else if (cur < lo || cur > hi) begin
                want = lo; tag = "R9";
              end else begin
                want = cur; tag = "R10";
              end
              apply(nw[0], dst, cur, busy, mode);
              if (!busy[want])    check(tag == "R10" ? "R6" : tag, 1'b1, 1'b0, 2'(want));
              else if (want < hi) check("R7", 1'b0, 1'b1, 2'(want + 1));
              else                check("R8", 1'b0, 1'b1, 2'(want));
            end
          end
        end
      end
    end

    @(negedge clk);
    req_valid = 1'b0;
    #1 check("R1", 1'b0, 1'b0, 2'd0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule